// File: doc/BRIEF.md
# Timed Serial Programming Decoder

This block sits behind the pin latches of a frequency synthesizer's select port. It watches a stream of latched 4-bit select writes. Each write arrives as a one-cycle valid strobe with its data. The same writes serve two purposes: choosing the active output frequency, and reprogramming one entry of the frequency table through a bit-serial frame. In the serial protocol, bit 3 of each write acts as the serial clock and bit 2 carries the data. Bits 0 and 1 play no part in programming.

The decoder times the gap between consecutive writes in reference-clock cycles. The design clock is the reference clock. A frame is accepted only if every gap lies between a minimum and a maximum interval, both scaled by the reference divider parameter. A complete 42-write frame with correct framing produces a one-cycle commit. The commit carries the table location, the feedback code, the post-divider code and the external-reference bit.

When writes stop for a long interval, the decoder emits a quiet pulse, applies the last written select value to its select output, and discards any partial frame. An aborted frame raises a one-cycle error flag and produces no commit.

Top module: `serial_prog_decoder`

## Requirements
- R1: After reset, commit_o, frame_err_o and quiet_o are 0, and vclk_sel_o and all commit fields are 0.
- R2: A frame is 42 writes. Payload bit k is taken from bit 2 of write 3+2k, the write whose bit 3 is 1 right after a write with bit 3 at 0. The payload order is: start, read/write, location (5 bits), feedback (8 bits), external-reference, post-divider (2 bits), stop, stop, with each field LSB first. commit_o pulses for one cycle, in the cycle after the 42nd write, with the decoded fields.
- R3: Writes 0 and 1 of a frame must have bit 3 at 0, with bit 2 equal to 0 and then 1. Payload writes must alternate bit 3 between 0 and 1, starting with 0. Any mismatch aborts the frame and pulses frame_err_o in the cycle after that write.
- R4: The start bit and the read/write bit must both be 0, and both stop bits must be 1. Otherwise the 42nd write pulses frame_err_o and produces no commit.
- R5: The gap between write edges inside a frame must lie in [6·REF_DIV, 4096·REF_DIV] cycles, bounds included (6 and 4096 by default). A gap outside this range aborts the frame with a frame_err_o pulse, and no commit follows.
- R6: A frame may start only on a write that comes at least 2·Tmax cycles after the previous write, or on the write right after a committed frame. Writes that are neither part of an open frame nor a legal start are ignored, with no commit and no error.
- R7: When no write occurs for 2·Tmax cycles after the last write edge (8192 by default), quiet_o is high for exactly the cycle after that edge, and vclk_sel_o takes the last written 4-bit value at that same time. vclk_sel_o changes at no other time.
- R8: Bits 0 and 1 of the writes have no effect on the decoded commit fields.
- R9: If the quiet interval ends a frame that is partly received, frame_err_o pulses together with quiet_o. The quiet pulse that follows a finished or aborted frame carries no error.
- R10: The commit fields hold their values until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; gaps are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe marking a latched select write |
| wr_sel | input | 4 | Latched select value; bit 3 serial clock, bit 2 serial data |
| commit_o | output | 1 | One-cycle pulse for an accepted frame |
| commit_loc_o | output | 5 | Table location of the accepted frame |
| commit_fb_o | output | 8 | Feedback divider code |
| commit_pd_o | output | 2 | Post-divider code |
| commit_ext_o | output | 1 | External-reference select bit |
| quiet_o | output | 1 | One-cycle pulse after a full quiet interval |
| vclk_sel_o | output | 4 | Active select, updated on the quiet pulse |
| frame_err_o | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The bench drives gaps of exactly 6 and 4096 cycles, which must be accepted, and gaps of 5 and 4097 cycles, which must abort. A decoder with off-by-one bounds would either drop legal frames or commit illegal ones. A second frame is chained straight after a commit with no quiet interval, and a complete valid frame is sent after an aborted one without a quiet interval. A decoder with the wrong start rule would reject the first of these or commit the second. The quiet pulse is timed to the exact cycle, and the bench checks whether it applies the last select and whether it carries an error. This catches a counter that is off by one, a select that updates on every write, and an abandoned partial frame that passes without an error.

// File: rtl/serial_prog_decoder.sv
module serial_prog_decoder #(
  parameter int REF_DIV = 1,
  parameter int MIN_MUL = 6,
  parameter int MAX_MUL = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [3:0] wr_sel,
  output logic       commit_o,
  output logic [4:0] commit_loc_o,
  output logic [7:0] commit_fb_o,
  output logic [1:0] commit_pd_o,
  output logic       commit_ext_o,
  output logic       quiet_o,
  output logic [3:0] vclk_sel_o,
  output logic       frame_err_o
);
  localparam int TMIN   = MIN_MUL * REF_DIV;
  localparam int TMAX   = MAX_MUL * REF_DIV;
  localparam int TQUIET = 2 * TMAX;
  localparam int CW     = $clog2(TQUIET + 1);
  localparam int PBITS  = 20;
  localparam logic [CW-1:0] TMIN_C = CW'(TMIN);
  localparam logic [CW-1:0] TMAX_C = CW'(TMAX);
  localparam logic [CW-1:0] SAT_C  = CW'(TQUIET);
  localparam logic [5:0]    LAST_C = 6'd41;

  logic [CW-1:0]    gap_q;
  logic             idle_q, active_q;
  logic [5:0]       idx_q;
  logic [PBITS-1:0] sh_q;
  logic [3:0]       last_q;

  wire sclk = wr_sel[3];
  wire sdat = wr_sel[2];
  wire at_sat  = (gap_q == SAT_C);
  wire start_w = wr_valid && (idle_q || at_sat);
  wire cont_w  = wr_valid && !start_w && active_q;
  wire gap_ok  = (gap_q >= TMIN_C) && (gap_q <= TMAX_C);
  wire take    = start_w || (cont_w && gap_ok);
  wire quiet_w = !wr_valid && at_sat && !idle_q;
  wire part_q  = active_q && (idx_q != 6'd0);

  wire [5:0] pos    = start_w ? 6'd0 : idx_q;
  wire       exp_ck = (pos >= 6'd2) && pos[0];
  wire       pre_ok = (pos >= 6'd2) || (sdat == pos[0]);
  wire       fmt_ok = (sclk == exp_ck) && pre_ok;
  wire       shift  = (pos >= 6'd2) && pos[0];

  wire [PBITS-1:0] sh_n = {sdat, sh_q[PBITS-1:1]};
  wire flags_ok = !sh_n[0] && !sh_n[1] && sh_n[18] && sh_n[19];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q        <= SAT_C;
      idle_q       <= 1'b1;
      active_q     <= 1'b0;
      idx_q        <= '0;
      sh_q         <= '0;
      last_q       <= '0;
      vclk_sel_o   <= '0;
      commit_o     <= 1'b0;
      frame_err_o  <= 1'b0;
      quiet_o      <= 1'b0;
      commit_loc_o <= '0;
      commit_fb_o  <= '0;
      commit_pd_o  <= '0;
      commit_ext_o <= 1'b0;
    end else begin
      commit_o    <= 1'b0;
      frame_err_o <= 1'b0;
      quiet_o     <= 1'b0;

      if (wr_valid) begin
        gap_q  <= CW'(1);
        idle_q <= 1'b0;
        last_q <= wr_sel;
      end else if (!at_sat) begin
        gap_q <= gap_q + 1'b1;
      end

      if (quiet_w) begin
        idle_q      <= 1'b1;
        quiet_o     <= 1'b1;
        vclk_sel_o  <= last_q;
        frame_err_o <= part_q;
        active_q    <= 1'b0;
        idx_q       <= '0;
        sh_q        <= '0;
      end else if (take) begin
        frame_err_o <= start_w && part_q;
        if (!fmt_ok) begin
          frame_err_o <= 1'b1;
          active_q    <= 1'b0;
          idx_q       <= '0;
          sh_q        <= '0;
        end else if (pos == LAST_C) begin
          idx_q <= '0;
          sh_q  <= '0;
          if (flags_ok) begin
            commit_o     <= 1'b1;
            commit_loc_o <= sh_n[6:2];
            commit_fb_o  <= sh_n[14:7];
            commit_ext_o <= sh_n[15];
            commit_pd_o  <= sh_n[17:16];
            active_q     <= 1'b1;
          end else begin
            frame_err_o <= 1'b1;
            active_q    <= 1'b0;
          end
        end else begin
          active_q <= 1'b1;
          idx_q    <= pos + 6'd1;
          if (pos == 6'd0) sh_q <= '0;
          else if (shift)  sh_q <= sh_n;
        end
      end else if (cont_w) begin
        frame_err_o <= 1'b1;
        active_q    <= 1'b0;
        idx_q       <= '0;
        sh_q        <= '0;
      end
    end
  end
endmodule

// File: rtl/serial_prog_decoder_chk.sv
module serial_prog_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [3:0] wr_sel,
  input logic       commit_o,
  input logic [4:0] commit_loc_o,
  input logic [7:0] commit_fb_o,
  input logic [1:0] commit_pd_o,
  input logic       commit_ext_o,
  input logic       quiet_o,
  input logic [3:0] vclk_sel_o,
  input logic       frame_err_o
);
  p_commit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_commit_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(wr_valid));

  p_commit_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !frame_err_o);

  p_quiet_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_o |=> !quiet_o);

  p_quiet_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_o |-> !$past(wr_valid));

  p_sel_on_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vclk_sel_o) |-> quiet_o);

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |-> $stable({commit_loc_o, commit_fb_o, commit_pd_o, commit_ext_o}));

  p_no_commit_on_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_o |-> !commit_o);
endmodule

bind serial_prog_decoder serial_prog_decoder_chk chk_i (.*);

// File: tb/serial_prog_decoder_tb_top.sv
module serial_prog_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [3:0] wr_sel = 4'd0;
  logic       commit_o, commit_ext_o, quiet_o, frame_err_o;
  logic [4:0] commit_loc_o;
  logic [7:0] commit_fb_o;
  logic [1:0] commit_pd_o;
  logic [3:0] vclk_sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit err_seen, commit_seen;

  localparam int QUIET = 8192;

  always #10 clk = ~clk;

  serial_prog_decoder dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [19:0] mk(input logic [4:0] loc, input logic [7:0] fb, input logic ext,
                                     input logic [1:0] pd, input logic st, input logic rw,
                                     input logic s1, input logic s2);
    return {s2, s1, pd, ext, fb, loc, rw, st};
  endfunction

  task automatic do_write(input logic [3:0] d, input int g);
    repeat (g - 1) @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [19:0] p, input int first_gap, input int nwr,
                            input int odd_idx, input int odd_gap, input bit junk);
    err_seen = 0;
    commit_seen = 0;
    for (int i = 0; i < nwr; i++) begin
      int g;
      logic [1:0] jj;
      logic [3:0] d;
      g  = (i == 0) ? first_gap : ((i == odd_idx) ? odd_gap : 6);
      jj = junk ? 2'(i * 3 + 1) : 2'b00;
      if (i < 2) d = {1'b0, i[0], jj};
      else       d = {i[0], p[(i - 2) / 2], jj};
      do_write(d, g);
      if (frame_err_o) err_seen = 1;
      if (commit_o) commit_seen = 1;
    end
  endtask

  task automatic wait_quiet();
    for (int k = 0; k < QUIET + 10; k++) begin
      @(negedge clk);
      if (quiet_o) return;
    end
    check(0, "wait_quiet", 0, 1);
  endtask

  task automatic t_reset();
    check(commit_o == 0 && frame_err_o == 0 && quiet_o == 0, "R1 pulses idle",
          {commit_o, frame_err_o, quiet_o}, 0);
    check(vclk_sel_o == 0, "R1 select", vclk_sel_o, 0);
    check({commit_loc_o, commit_fb_o, commit_pd_o, commit_ext_o} == 0, "R1 fields",
          {commit_loc_o, commit_fb_o, commit_pd_o, commit_ext_o}, 0);
  endtask

  task automatic t_basic();
    send_frame(mk(5'h13, 8'hA5, 1'b1, 2'b10, 0, 0, 1, 1), 1, 42, -1, 6, 1);
    check(commit_seen && !err_seen, "R2 commit", {commit_seen, err_seen}, 2);
    check(commit_loc_o == 5'h13, "R8 R2 location", commit_loc_o, 5'h13);
    check(commit_fb_o == 8'hA5, "R8 R2 feedback", commit_fb_o, 8'hA5);
    check(commit_ext_o == 1'b1 && commit_pd_o == 2'b10, "R2 ext/pd",
          {commit_ext_o, commit_pd_o}, 3'b110);
    @(negedge clk);
    check(commit_o == 0, "R2 one-cycle commit", commit_o, 0);
  endtask

  task automatic t_chain_tmax();
    repeat (4) @(negedge clk);
    send_frame(mk(5'h04, 8'h3C, 1'b0, 2'b01, 0, 0, 1, 1), 6, 42, 20, 4096, 0);
    check(commit_seen && !err_seen, "R6 R5 chained frame, gaps 6 and 4096",
          {commit_seen, err_seen}, 2);
    check(commit_loc_o == 5'h04 && commit_fb_o == 8'h3C, "R2 second frame fields",
          {commit_loc_o, commit_fb_o}, {5'h04, 8'h3C});
    check(commit_ext_o == 0 && commit_pd_o == 2'b01, "R2 second ext/pd",
          {commit_ext_o, commit_pd_o}, 3'b001);
  endtask

  task automatic t_quiet();
    repeat (QUIET - 1) @(negedge clk);
    check(quiet_o == 0 && vclk_sel_o == 0, "R7 no early quiet", {quiet_o, vclk_sel_o}, 0);
    check(commit_loc_o == 5'h04 && commit_fb_o == 8'h3C, "R10 fields held",
          {commit_loc_o, commit_fb_o}, {5'h04, 8'h3C});
    @(negedge clk);
    check(quiet_o == 1, "R7 quiet timing", quiet_o, 1);
    check(vclk_sel_o == 4'b1100, "R7 last select applied", vclk_sel_o, 4'b1100);
    check(frame_err_o == 0, "R9 no error after full frame", frame_err_o, 0);
    @(negedge clk);
    check(quiet_o == 0, "R7 quiet one cycle", quiet_o, 0);
  endtask

  task automatic t_gap(input int idx, input int g, input string req);
    send_frame(mk(5'h01, 8'h11, 0, 0, 0, 0, 1, 1), 1, 42, idx, g, 0);
    check(err_seen && !commit_seen, req, {err_seen, commit_seen}, 2);
    wait_quiet();
    check(frame_err_o == 0, "R9 no error after aborted frame", frame_err_o, 0);
  endtask

  task automatic t_flags(input logic st, input logic rw, input logic s1, input logic s2,
                         input string req);
    send_frame(mk(5'h0A, 8'hF0, 1, 2'b11, st, rw, s1, s2), 1, 42, -1, 6, 0);
    check(err_seen && !commit_seen, req, {err_seen, commit_seen}, 2);
    wait_quiet();
  endtask

  task automatic t_preamble_and_ignore();
    do_write(4'b1000, 1);
    check(frame_err_o == 1, "R3 bad preamble aborts", frame_err_o, 1);
    send_frame(mk(5'h07, 8'h55, 0, 0, 0, 0, 1, 1), 50, 42, -1, 6, 0);
    check(!err_seen && !commit_seen, "R6 writes without quiet ignored",
          {err_seen, commit_seen}, 0);
    wait_quiet();
  endtask

  task automatic t_payload_clock();
    send_frame(mk(5'h02, 8'h22, 0, 0, 0, 0, 1, 1), 1, 3, -1, 6, 0);
    do_write(4'b0000, 6);
    check(frame_err_o == 1, "R3 payload clock must alternate", frame_err_o, 1);
    wait_quiet();
  endtask

  task automatic t_abandon();
    send_frame(mk(5'h02, 8'h22, 0, 0, 0, 0, 1, 1), 1, 10, -1, 6, 0);
    wait_quiet();
    check(frame_err_o == 1, "R9 partial frame at quiet", frame_err_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chain_tmax();
    t_quiet();
    t_gap(15, 5, "R5 gap below minimum");
    t_gap(7, 4097, "R5 gap above maximum");
    t_flags(1, 0, 1, 1, "R4 start bit set");
    t_flags(0, 1, 1, 1, "R4 read/write bit set");
    t_flags(0, 0, 0, 1, "R4 first stop clear");
    t_flags(0, 0, 1, 0, "R4 second stop clear");
    t_preamble_and_ignore();
    t_payload_clock();
    t_abandon();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule